// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory Transfer Engine

This block moves data from a peripheral's data register into system memory without the processor running any code for it. Before a transfer, software loads three settings: the address of the peripheral register to read, the first memory address to fill, and a word count. The peripheral then raises its request line.

The engine asks the processor for the shared bus and waits until the processor grants it. It then acknowledges the peripheral and performs one read and one write per word. Every read uses the same source address. The destination address advances by one after each word. When the last word is written, the engine withdraws its bus request and its acknowledge together, releases the bus, and sets a completion flag.

The engine does not respond to a request again until the peripheral has lowered its request line at least once after the previous acknowledge.

Top module: `xfer_dma`

## Requirements
- R1: While and after synchronous reset, with no request pending, `bus_req`, `per_ack`, `bus_oe`, `bus_rd`, `bus_wr` and `done` are 0, and `bus_addr` and `bus_wdata` are 0.
- R2: When `cfg_we` is high in a cycle where the engine is idle, `cfg_wdata` is written to one register chosen by `cfg_sel`: 0 selects the source address, 1 the destination address, and 2 the word count (low `CW` bits). A write that arrives while a transfer is in progress, from the bus request until the return to idle, is ignored.
- R3: When `per_req` is high, the engine is idle and it is armed, `bus_req` rises one cycle later. It stays high until the cycle after the last write.
- R4: Before `bus_gnt` is seen, `per_ack` and `bus_oe` stay low. `bus_oe` is high only while `bus_gnt` is high. While the bus is released, `bus_addr` and `bus_wdata` read as 0.
- R5: In the cycle after the grant is seen, `per_ack` is high and a read of the source address is on the bus. Each word then takes one read cycle followed by one write cycle. The write carries the data sampled on `bus_rdata` during that read.
- R6: With count value n, the engine moves max(n,1) words. Word i goes to destination+i, with the address wrapping modulo 2^AW. The engine makes exactly that many reads and writes, holds `bus_req` for 2*max(n,1) cycles after the grant, and writes no other address.
- R7: In the cycle where `bus_req` falls, `per_ack` and `bus_oe` fall too. The engine stays out of idle until `bus_gnt` is low.
- R8: `done` rises together with the fall of `bus_req` after the last write. It stays high while the engine is idle and clears in the cycle where `bus_req` rises for the next transfer.
- R9: After an acknowledge, a `per_req` that stays high starts no new transfer. The engine becomes armed again once it has sampled `per_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| cfg_wdata | input | AW | Configuration write data |
| per_req | input | 1 | Peripheral data-ready request |
| per_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Request for the system bus, sent to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_oe | output | 1 | The engine is driving the bus |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid in the read cycle |
| done | output | 1 | Last transfer completed |

## Verification
The bench builds the engine with AW=8, DW=8 and CW=3. This keeps the whole count range 0 to 7 small enough to sweep completely, including the zero-count case. Each count is combined with grant delays of 0, 1 and 2 cycles, and every trial uses a fresh destination window. The peripheral model returns an incrementing value on each read of its register, so the expected memory contents and the read and write totals follow by arithmetic. The sweep also covers a configuration write made during the wait for the grant, and a request held high across the end of a transfer.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_READ,
    ST_WRITE,
    ST_REL
  } xfer_st_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
endpackage

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_sel)
        SEL_SRC: src_q <= cfg_wdata;
        SEL_DST: dst_q <= cfg_wdata;
        SEL_CNT: cnt_q <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && busy) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
endmodule

// File: rtl/xfer_dma_fsm.sv
module xfer_dma_fsm
  import xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          per_req,
  input  logic          bus_gnt,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          per_ack,
  output logic          bus_req,
  output logic          bus_oe,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  xfer_st_e      st, st_nx;
  logic          armed;
  logic [CW-1:0] left;
  logic [AW-1:0] dptr;
  logic          last_word;

  assign busy      = (st != ST_IDLE);
  assign last_word = (left == ONE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (per_req && armed) st_nx = ST_ASK;
      ST_ASK:   if (bus_gnt) st_nx = ST_READ;
      ST_READ:  st_nx = ST_WRITE;
      ST_WRITE: st_nx = last_word ? ST_REL : ST_READ;
      ST_REL:   if (!bus_gnt) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      armed     <= 1'b1;
      left      <= '0;
      dptr      <= '0;
      done      <= 1'b0;
      bus_req   <= 1'b0;
      per_ack   <= 1'b0;
      bus_oe    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_ASK && bus_gnt) armed <= 1'b0;
      else if (!per_req)           armed <= 1'b1;

      if (st == ST_IDLE && st_nx == ST_ASK) begin
        dptr <= dst_q;
        left <= (cnt_q == '0) ? ONE : cnt_q;
        done <= 1'b0;
      end else if (st == ST_WRITE) begin
        dptr <= dptr + AW'(1);
        left <= left - ONE;
        if (last_word) done <= 1'b1;
      end

      bus_req   <= (st_nx == ST_ASK) || (st_nx == ST_READ) || (st_nx == ST_WRITE);
      per_ack   <= (st_nx == ST_READ) || (st_nx == ST_WRITE);
      bus_oe    <= (st_nx == ST_READ) || (st_nx == ST_WRITE);
      bus_rd    <= (st_nx == ST_READ);
      bus_wr    <= (st_nx == ST_WRITE);
      bus_addr  <= (st_nx == ST_READ)  ? src_q :
                   (st_nx == ST_WRITE) ? dptr  : '0;
      bus_wdata <= (st_nx == ST_WRITE) ? bus_rdata : '0;
    end
  end

  // R4
  drive_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> bus_gnt);
  // R4
  ack_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(per_ack) |-> $past(bus_gnt));
  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr) |-> $past(bus_rd));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> ($fell(per_ack) && !bus_oe));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> $past(bus_wr));
  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(bus_req));
endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_oe,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done
);
  logic          busy;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  xfer_dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .busy(busy),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q)
  );

  xfer_dma_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .per_req(per_req), .bus_gnt(bus_gnt),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .bus_rdata(bus_rdata),
    .busy(busy), .per_ack(per_ack), .bus_req(bus_req), .bus_oe(bus_oe),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .done(done)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !per_ack && !bus_oe && !done));
endmodule

// File: tb/xfer_dma_bench.sv
`timescale 1ns/1ps
module xfer_dma_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic per_req = 1'b0;
  logic bus_gnt = 1'b0;
  logic per_ack, bus_req, bus_oe, bus_rd, bus_wr, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  xfer_dma #(.AW(AW), .DW(DW), .CW(CW)) u_xfer_dma (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_oe(bus_oe),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done)
  );

  logic [DW-1:0] mem [256];
  logic [AW-1:0] src_cur = '0, dst_cur = '0;
  logic [DW-1:0] pbase = '0;
  int neff = 1;
  logic clr = 1'b0;
  int rd_cnt = 0, wr_cnt = 0, bad_wr = 0;
  int total = 0, bad = 0;

  assign bus_rdata = (bus_addr == src_cur) ? DW'(pbase + DW'(rd_cnt)) : mem[bus_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (bus_oe && bus_wr) begin
      mem[bus_addr] <= bus_wdata;
    end
    if (clr) begin
      rd_cnt <= 0; wr_cnt <= 0; bad_wr <= 0;
    end else begin
      if (bus_oe && bus_rd) rd_cnt <= rd_cnt + 1;
      if (bus_oe && bus_wr) begin
        wr_cnt <= wr_cnt + 1;
        if (int'(AW'(bus_addr - dst_cur)) >= neff) bad_wr <= bad_wr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input int n, input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input int lat, input bit hold, input bit spoil, input logic [DW-1:0] base);
    int cyc, errs;
    bit first;
    neff = (n == 0) ? 1 : n;
    src_cur = src; dst_cur = dst; pbase = base;
    cfg_wr(2'd0, src);
    cfg_wr(2'd1, dst);
    cfg_wr(2'd2, AW'(n));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    per_req = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b1, "R3 request raised", int'(bus_req), 1);
    chk(done == 1'b0, "R8 done cleared at start", int'(done), 0);
    if (spoil) begin
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = '0;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk(!bus_oe && !per_ack && bus_req, "R4 idle before grant", int'(bus_oe), 0);
    end
    bus_gnt = 1'b1;
    cyc = 0; first = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (!bus_req) break;
      if (first)
        chk(per_ack && bus_rd && bus_oe && bus_addr == src, "R5 first read", int'(bus_addr), int'(src));
      first = 1'b0;
      cyc++;
    end
    chk(cyc == 2 * neff, "R6 bus hold cycles", cyc, 2 * neff);
    chk(!per_ack && !bus_oe && bus_addr == '0 && bus_wdata == '0, "R7 release", int'(per_ack), 0);
    chk(done == 1'b1, "R8 done set", int'(done), 1);
    bus_gnt = 1'b0;
    if (!hold) per_req = 1'b0;
    @(negedge clk);
    errs = 0;
    for (int i = 0; i < neff; i++)
      if (mem[AW'(dst + AW'(i))] != DW'(base + DW'(i))) errs++;
    chk(errs == 0, spoil ? "R2 busy write ignored" : "R5 data moved", errs, 0);
    chk(wr_cnt == neff && rd_cnt == neff && bad_wr == 0, "R6 word count", wr_cnt, neff);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !per_ack && !bus_oe && !done && bus_addr == '0, "R1 in reset", int'(bus_req), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_req && !per_ack && !bus_rd && !bus_wr && !done && bus_wdata == '0,
        "R1 after reset", int'(bus_req), 0);

    for (int n = 0; n < 8; n++)
      for (int lat = 0; lat < 3; lat++) begin
        int idx;
        idx = n * 3 + lat;
        run_xfer(n, AW'(8'hF0 + lat), AW'(8'h10 + idx * 9), lat, 1'b0,
                 (lat > 0) && idx[0], DW'(8'h30 + idx * 7));
      end

    // R9: request held high across the end of a transfer
    run_xfer(2, 8'hF8, 8'h08, 1, 1'b1, 1'b0, 8'h55);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(bus_req == 1'b0, "R9 no restart while req high", int'(bus_req), 0);
      chk(done == 1'b1, "R8 done held in idle", int'(done), 1);
    end
    per_req = 1'b0;
    @(negedge clk);
    per_req = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b1, "R9 rearmed after low", int'(bus_req), 1);
    chk(done == 1'b0, "R8 done cleared on restart", int'(done), 0);
    bus_gnt = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (!bus_req) break;
    end
    bus_gnt = 1'b0;
    per_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_req && !bus_oe && done, "R7 back to idle", int'(bus_req), 0);
    finish_run();
  end
endmodule